// File: doc/BRIEF.md
# Machine status and interrupt control-register file

This block holds the processor's machine status word, the interrupt-pending and interrupt-enable registers, and the supervisor trap vector. It also gives the supervisor-level views of these registers. Software reaches it through a single-cycle write port (strobe, 12-bit address, data) and a combinational read port. Each write is legalized field by field. A privilege or translation-mode field that receives an illegal encoding keeps its previous value, so the stored state never holds a value the core cannot act on.

The supervisor status, pending and enable addresses are not separate storage. They are remapped windows onto the machine registers, and each window exposes only its own subset of fields. A read-only summary-dirty bit sits at the top bit of the status word and is derived from the floating-point and extension state fields. When a status write changes the translation mode, the current or previous privilege, or the modify-privilege bit, the block raises a one-cycle TLB-flush pulse. A hardware input sets the machine timer-pending bit. A read of any address not listed below returns zero and raises an illegal-access flag.

Parameters: `XLEN` is the register width, 32 or 64. `HAS_EXT` is set when a custom extension unit is attached.

Top module: `sic_csr_file`

## Requirements
- R1: After reset, the machine status word (address 0x300) reads 0x96: PRV=M(3), PRV1=S(1), PRV2=S(1), all other fields 0. Pending (0x344), enable (0x304) and supervisor trap vector (0x105) read 0.
- R2: Privilege encodings are U=0, S=1, M=3, and 2 is illegal. A status write updates PRV (bits 2:1), PRV1 (bits 5:4) and PRV2 (bits 8:7) only when the written value is legal. Otherwise each field keeps its old value.
- R3: The VM field (bits 11:9) takes Bare=0 at any width. It takes Sv39=2 and Sv48=3 only when XLEN=64, and Sv32=1 only when XLEN=32. Any other written value leaves VM unchanged.
- R4: IE (bit 0), IE1 (bit 3), IE2 (bit 6), FS (bits 13:12) and MPRV (bit 16) always take the written value. XS (bits 15:14) is writable only when HAS_EXT=1 and otherwise stays 0. All other status bits read 0.
- R5: Bit XLEN-1 of the status word is read-only. It reads 1 exactly when FS=3 or XS=3.
- R6: `tlb_flush` is high for one cycle, in the cycle after a write to 0x300 or 0x100 that changes the stored VM, PRV, PRV1 or MPRV. Otherwise it is low.
- R7: A write to the pending register (0x344) changes only SSIP (bit 1), MSIP (bit 3) and STIP (bit 5). MTIP (bit 7) is left as it was.
- R8: A write to the enable register (0x304) changes SSIP, MSIP, STIP and MTIP, at bits 1, 3, 5 and 7.
- R9: `timer_set` sets MTIP in the following cycle, even when a pending-register write happens in the same cycle.
- R10: The supervisor pending view (0x144) writes only SSIP. It reads SSIP and STIP of the pending register and reads 0 in every other bit.
- R11: The supervisor enable view (0x104) reads and writes only SSIP and STIP of the enable register.
- R12: The supervisor status view (0x100) has IE at bit 0, PIE=IE1 at bit 1, PS=PRV1[0] at bit 2, FS at 4:3, XS at 6:5, MPRV at bit 7 and SD at bit XLEN-1. A write to it updates only those machine fields, writes PRV1 as {0,PS}, and is legalized as in R2 to R4.
- R13: A write to the supervisor trap vector (0x105) stores the data with its two low bits cleared.
- R14: A read of any other address returns 0 with `rd_illegal`=1. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | XLEN | Write data |
| rd_addr | input | 12 | Read address |
| rd_data | output | XLEN | Read data (combinational) |
| rd_illegal | output | 1 | Read address is not implemented |
| timer_set | input | 1 | Hardware request to set MTIP |
| tlb_flush | output | 1 | One-cycle translation flush request |

## Verification
Two instances run in lockstep against the same behavioural model: a 64-bit one with the extension and a 32-bit one without it. A VM write therefore shows the width-dependent acceptance, and an XS write shows the extension gate, in a single step. The directed patterns cover each illegal privilege and VM encoding, which separates keep-old from take-new behaviour. They also cover status writes that do and do not change the flush-relevant fields, all-ones writes through every alias (this exposes a mask that is too wide), and `timer_set` coinciding with a pending write. A long run of pseudo-random writes and reads over all addresses, including unimplemented ones, then checks every read and every flush cycle.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam logic [11:0] A_MSTATUS = 12'h300;
    localparam logic [11:0] A_MIE     = 12'h304;
    localparam logic [11:0] A_MIP     = 12'h344;
    localparam logic [11:0] A_SSTATUS = 12'h100;
    localparam logic [11:0] A_SIE     = 12'h104;
    localparam logic [11:0] A_SIP     = 12'h144;
    localparam logic [11:0] A_STVEC   = 12'h105;

    localparam int VM_W = 3;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;
    localparam logic [VM_W-1:0] VM_BARE = 3'd0;
    localparam logic [VM_W-1:0] VM_SV32 = 3'd1;
    localparam logic [VM_W-1:0] VM_SV39 = 3'd2;
    localparam logic [VM_W-1:0] VM_SV48 = 3'd3;

    // machine status layout
    localparam int P_IE   = 0;
    localparam int P_PRV  = 1;
    localparam int P_IE1  = 3;
    localparam int P_PRV1 = 4;
    localparam int P_IE2  = 6;
    localparam int P_PRV2 = 7;
    localparam int P_VM   = 9;
    localparam int P_FS   = 12;
    localparam int P_XS   = 14;
    localparam int P_MPRV = 16;

    // supervisor status layout
    localparam int S_IE   = 0;
    localparam int S_PIE  = 1;
    localparam int S_PS   = 2;
    localparam int S_FS   = 3;
    localparam int S_XS   = 5;
    localparam int S_MPRV = 7;

    // interrupt bit positions in the word; internal vector index 0..3
    localparam int I_SSIP = 1;
    localparam int I_MSIP = 3;
    localparam int I_STIP = 5;
    localparam int I_MTIP = 7;

    typedef struct packed {
        logic            mprv;
        logic [1:0]      xs;
        logic [1:0]      fs;
        logic [VM_W-1:0] vm;
        logic [1:0]      prv2;
        logic            ie2;
        logic [1:0]      prv1;
        logic            ie1;
        logic [1:0]      prv;
        logic            ie;
    } stat_t;

    function automatic logic priv_ok(logic [1:0] p);
        return (p == PRIV_U) || (p == PRIV_S) || (p == PRIV_M);
    endfunction

endpackage

// File: rtl/sic_status_wr.sv
module sic_status_wr
    import sic_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_EXT = 1'b1
) (
    input  stat_t           cur_i,
    input  logic            sview_i,
    input  logic [XLEN-1:0] wdata_i,
    output stat_t           nxt_o,
    output logic            chg_o
);

    stat_t cand;
    logic  vm_ok;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        cand = cur_i;
        if (sview_i) begin
            cand.ie   = wdata_i[S_IE];
            cand.ie1  = wdata_i[S_PIE];
            cand.prv1 = {1'b0, wdata_i[S_PS]};
            cand.fs   = wdata_i[S_FS +: 2];
            cand.xs   = wdata_i[S_XS +: 2];
            cand.mprv = wdata_i[S_MPRV];
        end else begin
            cand.ie   = wdata_i[P_IE];
            cand.prv  = wdata_i[P_PRV +: 2];
            cand.ie1  = wdata_i[P_IE1];
            cand.prv1 = wdata_i[P_PRV1 +: 2];
            cand.ie2  = wdata_i[P_IE2];
            cand.prv2 = wdata_i[P_PRV2 +: 2];
            cand.vm   = wdata_i[P_VM +: VM_W];
            cand.fs   = wdata_i[P_FS +: 2];
            cand.xs   = wdata_i[P_XS +: 2];
            cand.mprv = wdata_i[P_MPRV];
        end
    end

    generate
        if (XLEN == 64) begin : g_vm64
            assign vm_ok = (cand.vm == VM_BARE) || (cand.vm == VM_SV39) ||
                           (cand.vm == VM_SV48);
        end else begin : g_vm32
            assign vm_ok = (cand.vm == VM_BARE) || (cand.vm == VM_SV32);
        end
    endgenerate

    always_comb begin
        nxt_o      = cand;
        nxt_o.prv  = priv_ok(cand.prv)  ? cand.prv  : cur_i.prv;
        nxt_o.prv1 = priv_ok(cand.prv1) ? cand.prv1 : cur_i.prv1;
        nxt_o.prv2 = priv_ok(cand.prv2) ? cand.prv2 : cur_i.prv2;
        nxt_o.vm   = vm_ok ? cand.vm : cur_i.vm;
        nxt_o.xs   = HAS_EXT ? cand.xs : cur_i.xs;
        chg_o      = (nxt_o.vm != cur_i.vm) || (nxt_o.prv != cur_i.prv) ||
                     (nxt_o.prv1 != cur_i.prv1) || (nxt_o.mprv != cur_i.mprv);
    end

endmodule

// File: rtl/sic_read_mux.sv
module sic_read_mux
    import sic_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0]     addr_i,
    input  stat_t           st_i,
    input  logic [3:0]      ip_i,
    input  logic [3:0]      ie_i,
    input  logic [XLEN-1:0] tvec_i,
    output logic [XLEN-1:0] data_o,
    output logic            illegal_o
);

    logic [XLEN-1:0] mword;
    logic [XLEN-1:0] sword;
    logic            sd;

    function automatic logic [XLEN-1:0] spread(logic [3:0] b);
        logic [XLEN-1:0] w;
        w         = '0;
        w[I_SSIP] = b[0];
        w[I_MSIP] = b[1];
        w[I_STIP] = b[2];
        w[I_MTIP] = b[3];
        return w;
    endfunction

    always_comb begin
        sd                    = (&st_i.fs) | (&st_i.xs);
        mword                 = '0;
        mword[P_IE]           = st_i.ie;
        mword[P_PRV +: 2]     = st_i.prv;
        mword[P_IE1]          = st_i.ie1;
        mword[P_PRV1 +: 2]    = st_i.prv1;
        mword[P_IE2]          = st_i.ie2;
        mword[P_PRV2 +: 2]    = st_i.prv2;
        mword[P_VM +: VM_W]   = st_i.vm;
        mword[P_FS +: 2]      = st_i.fs;
        mword[P_XS +: 2]      = st_i.xs;
        mword[P_MPRV]         = st_i.mprv;
        mword[XLEN-1]         = sd;
        sword                 = '0;
        sword[S_IE]           = st_i.ie;
        sword[S_PIE]          = st_i.ie1;
        sword[S_PS]           = st_i.prv1[0];
        sword[S_FS +: 2]      = st_i.fs;
        sword[S_XS +: 2]      = st_i.xs;
        sword[S_MPRV]         = st_i.mprv;
        sword[XLEN-1]         = sd;

        illegal_o = 1'b0;
        case (addr_i)
            A_MSTATUS: data_o = mword;
            A_SSTATUS: data_o = sword;
            A_MIP:     data_o = spread(ip_i);
            A_MIE:     data_o = spread(ie_i);
            A_SIP:     data_o = spread({1'b0, ip_i[2], 1'b0, ip_i[0]});
            A_SIE:     data_o = spread({1'b0, ie_i[2], 1'b0, ie_i[0]});
            A_STVEC:   data_o = tvec_i;
            default: begin
                data_o    = '0;
                illegal_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sic_csr_file.sv
module sic_csr_file
    import sic_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [11:0]     wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [11:0]     rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_illegal,
    input  logic            timer_set,
    output logic            tlb_flush
);

    localparam int IRQ_N = 4;

    typedef struct packed {
        stat_t            st;
        logic [IRQ_N-1:0] ip;
        logic [IRQ_N-1:0] ie;
        logic [XLEN-1:0]  tvec;
        logic             flush;
    } regs_t;

    regs_t            r_d, r_q;
    stat_t            st_new;
    logic             st_chg;
    logic             sv_sel;
    logic [IRQ_N-1:0] ip_q_w;
    logic             unused_wr;

    assign sv_sel    = (wr_addr == A_SSTATUS);
    assign unused_wr = ^wr_data;

    sic_status_wr #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_status_wr (
        .cur_i   (r_q.st),
        .sview_i (sv_sel),
        .wdata_i (wr_data),
        .nxt_o   (st_new),
        .chg_o   (st_chg)
    );

    always_comb begin
        r_d       = r_q;
        r_d.flush = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_MSTATUS, A_SSTATUS: begin
                    r_d.st    = st_new;
                    r_d.flush = st_chg;
                end
                A_MIP: begin
                    r_d.ip[0] = wr_data[I_SSIP];
                    r_d.ip[1] = wr_data[I_MSIP];
                    r_d.ip[2] = wr_data[I_STIP];
                end
                A_MIE: begin
                    r_d.ie[0] = wr_data[I_SSIP];
                    r_d.ie[1] = wr_data[I_MSIP];
                    r_d.ie[2] = wr_data[I_STIP];
                    r_d.ie[3] = wr_data[I_MTIP];
                end
                A_SIP: r_d.ip[0] = wr_data[I_SSIP];
                A_SIE: begin
                    r_d.ie[0] = wr_data[I_SSIP];
                    r_d.ie[2] = wr_data[I_STIP];
                end
                A_STVEC: r_d.tvec = {wr_data[XLEN-1:2], 2'b00};
                default: ;
            endcase
        end
        if (timer_set) r_d.ip[3] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st.prv  <= PRIV_M;
            r_q.st.prv1 <= PRIV_S;
            r_q.st.prv2 <= PRIV_S;
        end else begin
            r_q <= r_d;
        end
    end

    assign tlb_flush = r_q.flush;
    assign ip_q_w    = r_q.ip;

    sic_read_mux #(.XLEN(XLEN)) u_read_mux (
        .addr_i    (rd_addr),
        .st_i      (r_q.st),
        .ip_i      (r_q.ip),
        .ie_i      (r_q.ie),
        .tvec_i    (r_q.tvec),
        .data_o    (rd_data),
        .illegal_o (rd_illegal)
    );

endmodule

// File: rtl/sic_csr_file_chk.sv
module sic_csr_file_chk
    import sic_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [11:0]     wr_addr,
    input logic [11:0]     rd_addr,
    input logic [XLEN-1:0] rd_data,
    input logic            rd_illegal,
    input logic            timer_set,
    input logic            tlb_flush,
    input logic [3:0]      ip_q
);

    logic unused_chk;
    assign unused_chk = ^{rd_data, ip_q};

    a_r14_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

    a_r2_priv_fields_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MSTATUS) |-> (rd_data[P_PRV +: 2] != 2'd2) &&
        (rd_data[P_PRV1 +: 2] != 2'd2) && (rd_data[P_PRV2 +: 2] != 2'd2));

    a_r3_vm_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MSTATUS) |-> (rd_data[P_VM +: VM_W] == VM_BARE) ||
        ((XLEN == 64) && ((rd_data[P_VM +: VM_W] == VM_SV39) ||
                          (rd_data[P_VM +: VM_W] == VM_SV48))) ||
        ((XLEN == 32) && (rd_data[P_VM +: VM_W] == VM_SV32)));

    a_r6_flush_after_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(wr_en && ((wr_addr == A_MSTATUS) || (wr_addr == A_SSTATUS))));

    a_r9_timer_sets_mtip: assert property (@(posedge clk) disable iff (!rst_n)
        timer_set |=> ip_q[3]);

    a_r13_tvec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_STVEC) |-> (rd_data[1:0] == 2'b00));

    a_r10_sip_hides_machine_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_SIP) |-> (rd_data[I_MSIP] == 1'b0) && (rd_data[I_MTIP] == 1'b0));

endmodule

bind sic_csr_file sic_csr_file_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal),
    .timer_set  (timer_set),
    .tlb_flush  (tlb_flush),
    .ip_q       (ip_q_w)
);

// File: tb/sic_csr_file_bench.sv
`timescale 1ns/1ps
module sic_csr_file_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic        timer_set = 1'b0;
    logic [63:0] rd64;
    logic [31:0] rd32;
    logic        ill64, ill32, fl64, fl32;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state: index 0 = 64-bit with extension, 1 = 32-bit without
    logic [63:0] m_st [2];
    logic [63:0] m_ip [2];
    logic [63:0] m_ie [2];
    logic [63:0] m_tv [2];
    logic        m_fl [2];

    always #10 clk = ~clk;

    sic_csr_file #(.XLEN(64), .HAS_EXT(1'b1)) u_sic_csr_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd64),
        .rd_illegal(ill64), .timer_set(timer_set), .tlb_flush(fl64));

    sic_csr_file #(.XLEN(32), .HAS_EXT(1'b0)) u_sic_csr_file_rv32 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data[31:0]), .rd_addr(rd_addr), .rd_data(rd32),
        .rd_illegal(ill32), .timer_set(timer_set), .tlb_flush(fl32));

    function automatic string tag_of(logic [11:0] a);
        case (a)
            12'h300: return "R1/R2/R3/R4/R5 mstatus";
            12'h100: return "R12 sstatus";
            12'h344: return "R7/R9 mip";
            12'h304: return "R8 mie";
            12'h144: return "R10 sip";
            12'h104: return "R11 sie";
            12'h105: return "R13 stvec";
            default: return "R14 unimplemented";
        endcase
    endfunction

    function automatic logic [63:0] legal_st(logic [63:0] old, logic [63:0] v,
                                             int xl, bit ext);
        logic [63:0] n;
        n = 64'h0;
        n[0] = v[0];
        n[3] = v[3];
        n[6] = v[6];
        n[16] = v[16];
        n[13:12] = v[13:12];
        n[15:14] = ext ? v[15:14] : old[15:14];
        n[2:1] = (v[2:1] == 2'd2) ? old[2:1] : v[2:1];
        n[5:4] = (v[5:4] == 2'd2) ? old[5:4] : v[5:4];
        n[8:7] = (v[8:7] == 2'd2) ? old[8:7] : v[8:7];
        if (v[11:9] == 3'd0 || (xl == 64 && (v[11:9] == 3'd2 || v[11:9] == 3'd3)) ||
            (xl == 32 && v[11:9] == 3'd1))
            n[11:9] = v[11:9];
        else
            n[11:9] = old[11:9];
        return n;
    endfunction

    function automatic logic [63:0] mread(int k, logic [11:0] a, output bit ill);
        logic [63:0] r;
        int xl;
        bit sd;
        xl  = (k == 0) ? 64 : 32;
        sd  = (m_st[k][13:12] == 2'd3) || (m_st[k][15:14] == 2'd3);
        ill = 1'b0;
        r   = 64'h0;
        case (a)
            12'h300: begin r = m_st[k]; r[xl-1] = sd; end
            12'h100: begin
                r[0] = m_st[k][0];
                r[1] = m_st[k][3];
                r[2] = m_st[k][4];
                r[4:3] = m_st[k][13:12];
                r[6:5] = m_st[k][15:14];
                r[7] = m_st[k][16];
                r[xl-1] = sd;
            end
            12'h344: r = m_ip[k];
            12'h304: r = m_ie[k];
            12'h144: r = m_ip[k] & 64'h22;
            12'h104: r = m_ie[k] & 64'h22;
            12'h105: r = m_tv[k];
            default: ill = 1'b1;
        endcase
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit we, logic [11:0] wa, logic [63:0] wd,
                        logic [11:0] ra, bit ts);
        logic [63:0] exp_d;
        logic [63:0] old;
        logic [63:0] v;
        bit          exp_i;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; timer_set = ts;
        #1;
        for (int k = 0; k < 2; k++) begin
            exp_d = mread(k, ra, exp_i);
            if (k == 0) begin
                chk(tag_of(ra), rd64, exp_d);
                chk("R14 illegal flag", {63'h0, ill64}, {63'h0, exp_i});
                chk("R6 tlb_flush", {63'h0, fl64}, {63'h0, m_fl[k]});
            end else begin
                chk(tag_of(ra), {32'h0, rd32}, {32'h0, exp_d[31:0]});
                chk("R14 illegal flag", {63'h0, ill32}, {63'h0, exp_i});
                chk("R6 tlb_flush", {63'h0, fl32}, {63'h0, m_fl[k]});
            end
        end
        for (int k = 0; k < 2; k++) begin
            int xl;
            xl = (k == 0) ? 64 : 32;
            v = (k == 0) ? wd : {32'h0, wd[31:0]};
            m_fl[k] = 1'b0;
            if (we) begin
                old = m_st[k];
                case (wa)
                    12'h300: m_st[k] = legal_st(old, v, xl, k == 0);
                    12'h100: begin
                        logic [63:0] c;
                        c = old;
                        c[0] = v[0];
                        c[3] = v[1];
                        c[5:4] = {1'b0, v[2]};
                        c[13:12] = v[4:3];
                        c[15:14] = v[6:5];
                        c[16] = v[7];
                        m_st[k] = legal_st(old, c, xl, k == 0);
                    end
                    12'h344: m_ip[k] = (m_ip[k] & ~64'h2A) | (v & 64'h2A);
                    12'h304: m_ie[k] = (m_ie[k] & ~64'hAA) | (v & 64'hAA);
                    12'h144: m_ip[k] = (m_ip[k] & ~64'h02) | (v & 64'h02);
                    12'h104: m_ie[k] = (m_ie[k] & ~64'h22) | (v & 64'h22);
                    12'h105: m_tv[k] = v & ~64'h3;
                    default: ;
                endcase
                if (wa == 12'h300 || wa == 12'h100)
                    m_fl[k] = (old[11:9] != m_st[k][11:9]) || (old[2:1] != m_st[k][2:1]) ||
                              (old[5:4] != m_st[k][5:4]) || (old[16] != m_st[k][16]);
            end
            if (ts) m_ip[k] = m_ip[k] | 64'h80;
        end
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d);
        step(1'b1, a, d, a, 1'b0);
        step(1'b0, 12'h0, 64'h0, a, 1'b0);
    endtask

    initial begin
        logic [11:0] addrs [9];
        addrs = '{12'h300, 12'h100, 12'h344, 12'h304, 12'h144, 12'h104,
                  12'h105, 12'h7C0, 12'h301};
        for (int k = 0; k < 2; k++) begin
            m_st[k] = 64'h96; m_ip[k] = 0; m_ie[k] = 0; m_tv[k] = 0; m_fl[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, R14 unimplemented read
        foreach (addrs[i]) step(1'b0, 12'h0, 64'h0, addrs[i], 1'b0);
        // R2 illegal PRV=2 keeps M, other privilege fields legal
        wr(12'h300, 64'h0000_0000_0000_0094);
        wr(12'h300, 64'h0000_0000_0000_01A6);
        // R3 VM: Sv32, Sv39, Sv48, illegal 5, bare
        wr(12'h300, 64'h0000_0000_0000_0200 | 64'h96);
        wr(12'h300, 64'h0000_0000_0000_0400 | 64'h96);
        wr(12'h300, 64'h0000_0000_0000_0600 | 64'h96);
        wr(12'h300, 64'h0000_0000_0000_0A00 | 64'h96);
        wr(12'h300, 64'h0000_0000_0000_0096);
        // R4/R5 FS, XS, enables, MPRV, stray bits and SD not writable
        wr(12'h300, 64'hFFFF_FFFF_FFFE_3096);
        wr(12'h300, 64'h8000_0000_0001_C0DF);
        wr(12'h300, 64'h0000_0000_0000_0096);
        // R6 status write with no relevant change: no flush
        wr(12'h300, 64'h0000_0000_0000_0097);
        // R12 supervisor status view
        wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h100, 64'h0000_0000_0000_0000);
        wr(12'h100, 64'h0000_0000_0000_0084);
        // R7/R8 machine pending and enable
        wr(12'h344, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h304, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h304, 64'h0);
        // R9 timer_set together with a pending write of zeros
        step(1'b1, 12'h344, 64'h0, 12'h344, 1'b1);
        step(1'b0, 12'h0, 64'h0, 12'h344, 1'b0);
        // R10/R11 supervisor pending and enable
        wr(12'h144, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h104, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h104, 64'h0);
        // R13 trap vector alignment
        wr(12'h105, 64'hFFFF_FFFF_FFFF_FFFF);
        // R14 writes to unimplemented addresses leave all registers alone
        step(1'b1, 12'h7C0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h7C0, 1'b0);
        step(1'b1, 12'h301, 64'hFFFF_FFFF_FFFF_FFFF, 12'h301, 1'b0);
        foreach (addrs[i]) step(1'b0, 12'h0, 64'h0, addrs[i], 1'b0);
        // mixed pseudo-random traffic
        for (int n = 0; n < 1500; n++) begin
            int wi, ri;
            wi = $urandom_range(0, 8);
            ri = $urandom_range(0, 8);
            step($urandom_range(0, 1) == 1, addrs[wi], {$urandom, $urandom},
                 addrs[ri], $urandom_range(0, 15) == 0);
        end
        step(1'b0, 12'h0, 64'h0, 12'h300, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule